// File: doc/BRIEF.md
# Divider Configuration Source Selector

This block supplies the divider settings for a clock synthesizer. The settings are a 10-bit feedback divider, a 3-bit divider for the first output group, a 1-bit divider for the second output group and a 1-bit reference pre-divider. A mode input chooses where the active settings come from. With the mode input low, the settings track a set of configuration pins. With it high, they come from a small register bank instead. The bank is filled with fixed defaults while reset is held, and a byte-wide write port can change it afterwards.

A byte-wide read port returns either the bank contents or a synchronized copy of the configuration pins. The pin copy can be read in both modes, so software can see the strapped setting even while the bank drives the synthesizer. A one-cycle pulse marks each cycle in which the active feedback divider or pre-divider changes, because such a change can make the loop lose lock.

All pins and the mode input pass through a synchronizer before use. Reset is synchronous and active high. It must be held for at least as many cycles as the synchronizer has stages.

Top module: `cfg_source_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the active outputs hold the defaults (feedback 100, first-group divider 1, second-group divider 0, pre-divider 0) and the reload pulse is low.
- R2: With the synchronized mode low, the active outputs equal the configuration pins. A pin change appears on the active outputs after the third rising clock edge that follows it, and not earlier.
- R3: With the synchronized mode high, changes on the configuration pins have no effect on the active outputs or on the reload pulse. The active outputs equal the register bank.
- R4: A write to address 0 loads wr_data[7:0] into feedback bits 7:0. A write to address 1 loads feedback bits 9:8 from wr_data[1:0], the first-group divider from wr_data[4:2], the second-group divider from wr_data[5] and the pre-divider from wr_data[6]. wr_data[7] is ignored. In serial mode the written value reaches the active outputs one cycle after the write edge.
- R5: Writes to addresses 2 and 3 change neither the bank nor the active outputs.
- R6: Reads are registered and return data one edge after rd_addr is presented. Address 0 gives bank feedback bits 7:0. Address 1 gives the bank in the address-1 layout of R4 with bit 7 zero. Addresses 2 and 3 give the synchronized pins in those same two layouts. All of this holds in both modes.
- R7: reload_pulse is high for exactly the cycles in which the active feedback divider or pre-divider differs from its value in the previous cycle. Changes confined to the two output-group dividers produce no pulse.
- R8: A change of the mode input takes effect on the active outputs after the third rising clock edge that follows it.
- R9: Each assertion of reset returns the register bank to the defaults of R1, whatever was written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | Source select: 0 for the pins, 1 for the register bank |
| pin_fb | input | 10 | Feedback divider pins |
| pin_na | input | 3 | First output-group divider pins |
| pin_nb | input | 1 | Second output-group divider pin |
| pin_pre | input | 1 | Pre-divider pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| act_fb | output | 10 | Active feedback divider |
| act_na | output | 3 | Active first output-group divider |
| act_nb | output | 1 | Active second output-group divider |
| act_pre | output | 1 | Active pre-divider |
| reload_pulse | output | 1 | One-cycle mark of a feedback or pre-divider change |

## Verification
Pin and mode changes reach the active outputs on the third edge after they are applied. Register writes reach them on the second edge, and read data is due on the first edge after the address. The reload pulse comes in the same cycle as the active change it marks. The directed latency checks sample just after each of those edges, and also one edge before, to show that nothing arrives early. The random phase applies one kind of change at a time, waits five edges while counting pulses, and then compares outputs and read data that no longer move.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;

    localparam int FB_W   = 10;
    localparam int NA_W   = 3;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef struct packed {
        logic [FB_W-1:0] fb;
        logic [NA_W-1:0] na;
        logic            nb;
        logic            pre;
    } div_cfg_t;

    localparam int CFG_W = $bits(div_cfg_t);

    typedef enum logic [ADDR_W-1:0] {
        ADR_BANK_LO = 2'd0,
        ADR_BANK_HI = 2'd1,
        ADR_PIN_LO  = 2'd2,
        ADR_PIN_HI  = 2'd3
    } reg_addr_e;

    // Low byte view: feedback bits 7:0.
    function automatic logic [BYTE_W-1:0] cfg_lo_byte(div_cfg_t c);
        return c.fb[BYTE_W-1:0];
    endfunction

    // High byte view: {0, pre, nb, na, fb[9:8]}.
    function automatic logic [BYTE_W-1:0] cfg_hi_byte(div_cfg_t c);
        return {1'b0, c.pre, c.nb, c.na, c.fb[FB_W-1:BYTE_W]};
    endfunction

    function automatic div_cfg_t cfg_put_lo(div_cfg_t c, logic [BYTE_W-1:0] d);
        div_cfg_t r;
        r = c;
        r.fb[BYTE_W-1:0] = d;
        return r;
    endfunction

    function automatic div_cfg_t cfg_put_hi(div_cfg_t c, logic [BYTE_W-1:0] d);
        div_cfg_t r;
        r = c;
        r.fb[FB_W-1:BYTE_W] = d[1:0];
        r.na                = d[4:2];
        r.nb                = d[5];
        r.pre               = d[6];
        return r;
    endfunction

    // Only the loop-affecting fields call for a reload mark.
    function automatic logic cfg_needs_reload(div_cfg_t a, div_cfg_t b);
        return (a.fb != b.fb) || (a.pre != b.pre);
    endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) stage_q[i] <= d;
            end else begin : g_next
                always_ff @(posedge clk) stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_sel_pkg::*;
#(
    parameter div_cfg_t DEF_CFG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  div_cfg_t          pin_cfg,
    output div_cfg_t          bank_cfg,
    output logic [BYTE_W-1:0] rd_data
);

    div_cfg_t          bank_q;
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= DEF_CFG;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADR_BANK_LO: bank_q <= cfg_put_lo(bank_q, wr_data);
                ADR_BANK_HI: bank_q <= cfg_put_hi(bank_q, wr_data);
                default:     bank_q <= bank_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            case (reg_addr_e'(rd_addr))
                ADR_BANK_LO: rd_q <= cfg_lo_byte(bank_q);
                ADR_BANK_HI: rd_q <= cfg_hi_byte(bank_q);
                ADR_PIN_LO:  rd_q <= cfg_lo_byte(pin_cfg);
                default:     rd_q <= cfg_hi_byte(pin_cfg);
            endcase
        end
    end

    assign bank_cfg = bank_q;
    assign rd_data  = rd_q;

    // R9: the bank holds the defaults when reset has just been released
    a_r9_bank_defaults: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bank_q == DEF_CFG));

    // R5: writes to the pin-snapshot addresses leave the bank alone
    a_r5_pin_addr_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[1]) |=> $stable(bank_q));

    // R6: the pin low byte read returns the synchronized pins
    a_r6_pin_lo_read: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADR_PIN_LO) |=> (rd_data == $past(pin_cfg.fb[BYTE_W-1:0])));

endmodule

// File: rtl/cfg_source_sel.sv
module cfg_source_sel
    import cfg_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEF_FB      = 100,
    parameter int DEF_NA      = 1,
    parameter int DEF_NB      = 0,
    parameter int DEF_PRE     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic [FB_W-1:0]   pin_fb,
    input  logic [NA_W-1:0]   pin_na,
    input  logic              pin_nb,
    input  logic              pin_pre,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [FB_W-1:0]   act_fb,
    output logic [NA_W-1:0]   act_na,
    output logic              act_nb,
    output logic              act_pre,
    output logic              reload_pulse
);

    localparam div_cfg_t DEF_CFG = '{
        fb:  FB_W'(DEF_FB),
        na:  NA_W'(DEF_NA),
        nb:  1'(DEF_NB),
        pre: 1'(DEF_PRE)
    };
    localparam int SYNC_W = CFG_W + 1;

    div_cfg_t          pin_raw;
    div_cfg_t          pin_s;
    logic              mode_s;
    logic [SYNC_W-1:0] sync_out;
    div_cfg_t          bank_cfg;
    div_cfg_t          sel_cfg;
    div_cfg_t          act_q;
    logic              pulse_q;

    assign pin_raw = '{fb: pin_fb, na: pin_na, nb: pin_nb, pre: pin_pre};

    cfg_pin_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d   ({serial_mode, pin_raw}),
        .q   (sync_out)
    );

    assign mode_s = sync_out[SYNC_W-1];
    assign pin_s  = div_cfg_t'(sync_out[CFG_W-1:0]);

    cfg_reg_bank #(
        .DEF_CFG (DEF_CFG)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .pin_cfg  (pin_s),
        .bank_cfg (bank_cfg),
        .rd_data  (rd_data)
    );

    always_comb sel_cfg = mode_s ? bank_cfg : pin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= DEF_CFG;
            pulse_q <= 1'b0;
        end else begin
            act_q   <= sel_cfg;
            pulse_q <= cfg_needs_reload(sel_cfg, act_q);
        end
    end

    assign act_fb       = act_q.fb;
    assign act_na       = act_q.na;
    assign act_nb       = act_q.nb;
    assign act_pre      = act_q.pre;
    assign reload_pulse = pulse_q;

    // R1: defaults and a quiet pulse at the first cycle out of reset
    a_r1_release_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (act_q == DEF_CFG && !pulse_q));

    // R2: in pin mode the outputs follow the synchronizer one edge later
    a_r2_pin_follow: assert property (@(posedge clk) disable iff (rst)
        !mode_s |=> (act_q == $past(pin_s)));

    // R3: in serial mode the outputs follow the bank one edge later
    a_r3_bank_follow: assert property (@(posedge clk) disable iff (rst)
        mode_s |=> (act_q == $past(bank_cfg)));

    // R7: a pulse exactly when feedback or pre-divider moved
    a_r7_pulse_iff_change: assert property (@(posedge clk) disable iff (rst)
        pulse_q == ((act_q.fb != $past(act_q.fb)) || (act_q.pre != $past(act_q.pre))));

endmodule

// File: tb/cfg_source_sel_tb.sv
module cfg_source_sel_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       serial_mode;
    logic [9:0] pin_fb;
    logic [2:0] pin_na;
    logic       pin_nb;
    logic       pin_pre;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic [9:0] act_fb;
    logic [2:0] act_na;
    logic       act_nb;
    logic       act_pre;
    logic       reload_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    // Bench model of the bank
    logic [9:0] b_fb;
    logic [2:0] b_na;
    logic       b_nb;
    logic       b_pre;
    logic       m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_source_sel u_dut (
        .clk          (clk),
        .rst          (rst),
        .serial_mode  (serial_mode),
        .pin_fb       (pin_fb),
        .pin_na       (pin_na),
        .pin_nb       (pin_nb),
        .pin_pre      (pin_pre),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .act_fb       (act_fb),
        .act_na       (act_na),
        .act_nb       (act_nb),
        .act_pre      (act_pre),
        .reload_pulse (reload_pulse)
    );

    function automatic logic [14:0] pk(logic [9:0] f, logic [2:0] a, logic b, logic p);
        return {f, a, b, p};
    endfunction

    function automatic logic [7:0] hi_view(logic [9:0] f, logic [2:0] a, logic b, logic p);
        return {1'b0, p, b, a, f[9:8]};
    endfunction

    function automatic logic [14:0] act_now();
        return pk(act_fb, act_na, act_nb, act_pre);
    endfunction

    function automatic logic [14:0] exp_act();
        return m_mode ? pk(b_fb, b_na, b_nb, b_pre) : pk(pin_fb, pin_na, pin_nb, pin_pre);
    endfunction

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (reload_pulse) pulses++;
    endtask

    task automatic bank_defaults();
        b_fb = 10'd100; b_na = 3'd1; b_nb = 1'b0; b_pre = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) tick();
        chk(act_now() == pk(10'd100, 3'd1, 1'b0, 1'b0), "R1 during reset", int'(act_now()),
            int'(pk(10'd100, 3'd1, 1'b0, 1'b0)));
        chk(reload_pulse == 1'b0, "R1 pulse in reset", int'(reload_pulse), 0);
        rst = 1'b0;
        bank_defaults();
    endtask

    task automatic read_all(input string tag);
        rd_addr = 2'd0; tick();
        chk(rd_data == b_fb[7:0], {tag, " R6 bank lo"}, int'(rd_data), int'(b_fb[7:0]));
        rd_addr = 2'd1; tick();
        chk(rd_data == hi_view(b_fb, b_na, b_nb, b_pre), {tag, " R6 bank hi"}, int'(rd_data),
            int'(hi_view(b_fb, b_na, b_nb, b_pre)));
        rd_addr = 2'd2; tick();
        chk(rd_data == pin_fb[7:0], {tag, " R6 pin lo"}, int'(rd_data), int'(pin_fb[7:0]));
        rd_addr = 2'd3; tick();
        chk(rd_data == hi_view(pin_fb, pin_na, pin_nb, pin_pre), {tag, " R6 pin hi"},
            int'(rd_data), int'(hi_view(pin_fb, pin_na, pin_nb, pin_pre)));
    endtask

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0) b_fb[7:0] = d;
        else if (a == 2'd1) begin
            b_fb[9:8] = d[1:0]; b_na = d[4:2]; b_nb = d[5]; b_pre = d[6];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] prev;
        void'($urandom(32'd1234));
        rst = 1'b1; serial_mode = 1'b1; m_mode = 1'b1;
        pin_fb = 10'd555; pin_na = 3'd6; pin_nb = 1'b1; pin_pre = 1'b1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        bank_defaults();

        // R1: reset state and first cycle after release, serial mode
        do_reset();
        tick();
        chk(act_now() == pk(10'd100, 3'd1, 1'b0, 1'b0), "R1 after release", int'(act_now()),
            int'(pk(10'd100, 3'd1, 1'b0, 1'b0)));
        chk(reload_pulse == 1'b0, "R1 pulse after release", int'(reload_pulse), 0);
        repeat (3) tick();
        // R3: pins differ from defaults and are ignored
        chk(act_now() == pk(10'd100, 3'd1, 1'b0, 1'b0), "R3 pins ignored", int'(act_now()),
            int'(pk(10'd100, 3'd1, 1'b0, 1'b0)));
        read_all("serial");

        // R4: write latency, address 0
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h3C; model_write(2'd0, 8'h3C);
        tick(); wr_en = 1'b0;
        chk(act_fb == 10'd100, "R4 not before second edge", int'(act_fb), 100);
        pulses = 0;
        tick();
        chk(act_fb == 10'h03C, "R4 fb low byte", int'(act_fb), 'h3C);
        chk(reload_pulse == 1'b1, "R7 pulse on fb change", int'(reload_pulse), 1);
        tick();
        chk(reload_pulse == 1'b0, "R7 pulse single cycle", int'(reload_pulse), 0);

        // R4/R7: address 1 changing only na and nb, bit 7 set
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'b1011_1000; model_write(2'd1, 8'b1011_1000);
        pulses = 0;
        tick(); wr_en = 1'b0; tick(); tick();
        chk(act_now() == pk(10'h03C, 3'd6, 1'b1, 1'b0), "R4 hi fields", int'(act_now()),
            int'(pk(10'h03C, 3'd6, 1'b1, 1'b0)));
        chk(pulses == 0, "R7 no pulse for na/nb", pulses, 0);

        // R5: writes to addresses 2 and 3 ignored
        pulses = 0;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hFF; tick();
        wr_addr = 2'd3; wr_data = 8'h7F; tick(); wr_en = 1'b0;
        repeat (3) tick();
        chk(act_now() == pk(10'h03C, 3'd6, 1'b1, 1'b0), "R5 active unchanged", int'(act_now()),
            int'(pk(10'h03C, 3'd6, 1'b1, 1'b0)));
        chk(pulses == 0, "R5 no pulse", pulses, 0);
        read_all("R5");

        // R8: mode switch latency to pins
        serial_mode = 1'b0; m_mode = 1'b0; pulses = 0;
        tick(); tick();
        chk(act_now() == pk(10'h03C, 3'd6, 1'b1, 1'b0), "R8 not before third edge",
            int'(act_now()), int'(pk(10'h03C, 3'd6, 1'b1, 1'b0)));
        tick();
        chk(act_now() == exp_act(), "R8 switched to pins", int'(act_now()), int'(exp_act()));
        chk(reload_pulse == 1'b1, "R7 pulse on mode switch", int'(reload_pulse), 1);

        // R2: pin latency in parallel mode
        tick();
        pin_pre = 1'b0;
        tick(); tick();
        chk(act_pre == 1'b1, "R2 not before third edge", int'(act_pre), 1);
        tick();
        chk(act_pre == 1'b0, "R2 pin tracked", int'(act_pre), 0);
        chk(reload_pulse == 1'b1, "R7 pulse on pre change", int'(reload_pulse), 1);
        tick();
        read_all("parallel");

        // Random phase: one change at a time
        for (int it = 0; it < 300; it++) begin
            int op;
            prev = exp_act();
            op = $urandom_range(0, 2);
            if (op == 0) begin
                pin_fb = 10'($urandom); pin_na = 3'($urandom);
                pin_nb = 1'($urandom); pin_pre = 1'($urandom);
            end else if (op == 1) begin
                wr_en = 1'b1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
                model_write(wr_addr, wr_data);
            end else begin
                m_mode = ~m_mode; serial_mode = m_mode;
            end
            pulses = 0;
            tick(); wr_en = 1'b0;
            repeat (4) tick();
            chk(act_now() == exp_act(), m_mode ? "R3 random serial" : "R2 random parallel",
                int'(act_now()), int'(exp_act()));
            chk(pulses == ((prev[14:5] != exp_act()[14:5] || prev[0] != exp_act()[0]) ? 1 : 0),
                "R7 random pulse count", pulses,
                (prev[14:5] != exp_act()[14:5] || prev[0] != exp_act()[0]) ? 1 : 0);
            read_all("random");
        end

        // R9: reset restores bank defaults
        serial_mode = 1'b1; m_mode = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h11; tick(); wr_en = 1'b0;
        do_reset();
        repeat (4) tick();
        chk(act_now() == pk(10'd100, 3'd1, 1'b0, 1'b0), "R9 active defaults", int'(act_now()),
            int'(pk(10'd100, 3'd1, 1'b0, 1'b0)));
        read_all("R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule